// File: doc/BRIEF.md
# Multiplexed Bidirectional GPIO Port

An eight-pin general-purpose I/O port whose pins can also be claimed by neighbouring functions. Software sees three registers through a small synchronous register bus: a direction register (a 1 makes the pin an input, a 0 makes it drive), an output latch, and a port register that returns the synchronized pin levels on read and writes the latch on write. A pad ring consumes the per-pin output-enable and output-value signals and returns the raw pin levels.

Ownership of each pin follows a small state machine fed by the memory-mode selection and the enable bits that sit in other blocks. The states are `OWN_BUS` (external bus drives all pins as the high address/data byte), `OWN_PSP` (pins 0..2 are parallel-slave-port strobes), `OWN_ALT` (pin 7 carries the capture/compare output), `OWN_PSP_ALT` (both of the previous overlays) and `OWN_GPIO` (no override). Every cycle the next state is decoded from the inputs: any bus mode with the bus enabled moves to `OWN_BUS`; microcontroller mode moves to `OWN_PSP`, `OWN_ALT`, `OWN_PSP_ALT` or `OWN_GPIO` from the two overlay bits; a bus mode with the bus disabled moves to `OWN_GPIO`. Any state can reach any other state in one clock. The reset is synchronous and also loads the decoded state, so in a bus mode the bus owns the pins from the first reset edge. Direction and latch values survive overrides and come back into force when the override ends.

Top module: `gpio_mux_port`

## Requirements
- R1: While reset is asserted, the latch reads 8'h00, the direction register reads 8'hFF, and in microcontroller mode (mem_mode 2'b00) with no overlay active no pin is driven.
- R2: With no override, a pin whose direction bit is 0 has pad_oe=1 and pad_out equal to its latch bit; a pin whose direction bit is 1 has pad_oe=0. Each pin follows its own bit.
- R3: Reading address 2'b01 returns the latch contents, not the pin levels.
- R4: A write to address 2'b00 or 2'b01 loads the latch at that clock edge; a read of address 2'b00 returns pad_in as sampled through two flops, so a pin change is visible after the second rising edge. Address 2'b10 is the direction register.
- R5: In a bus mode (mem_mode 2'b01, 2'b10 or 2'b11) with bus_dis=0, every pin has pad_oe=bus_drive and pad_out=bus_out.
- R6: In a bus mode with bus_dis=1, all eight pins behave as plain GPIO; the overlay bits have no effect.
- R7: In microcontroller mode with psp_en=1, pins 0..2 are never driven (pad_oe=0, pad_out=0); psp_ctl carries the synchronized levels of pins 0..2 only when direction bits 2..0 are all 1, and reads 3'b111 otherwise.
- R8: In microcontroller mode with alt_sel_n=0, pin 7 has pad_oe=ccp_drive and pad_out=ccp_out.
- R9: While a pin is overridden its direction and latch bits keep their values and drive the pin again once the override ends.
- R10: With mem_mode 2'b10 and bus_dis=0, the bus owns every pin one edge into reset and stays owner after reset is released.
- R11: Address 2'b11 reads as 8'h00 and writes to it change neither the latch nor the direction register.
- R12: A change of mode or enable inputs reaches pad_oe and pad_out after exactly one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 port, 1 latch, 2 direction, 3 unused |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| mem_mode | input | 2 | 00 microcontroller, others external-bus modes |
| bus_dis | input | 1 | Disables external-bus ownership in bus modes |
| psp_en | input | 1 | Parallel-slave-port enable (microcontroller mode) |
| alt_sel_n | input | 1 | 0 routes capture/compare output to pin 7 (microcontroller mode) |
| bus_drive | input | 1 | External bus output enable |
| bus_out | input | 8 | External bus high byte out |
| bus_in | output | 8 | Synchronized pin levels for the external bus |
| ccp_drive | input | 1 | Capture/compare output enable |
| ccp_out | input | 1 | Capture/compare output value |
| psp_ctl | output | 3 | Synchronized read/write/select strobes from pins 0..2 |
| pad_in | input | 8 | Raw pin levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |

## Verification
Every cycle the assertions check the ownership results against the inputs of the previous cycle: bus ownership of all pins, undriven strobe pins, the alternate output on pin 7, GPIO direction following, latch loading on writes, the inert unused address and the reset values. Only the bench scenarios can show that latch and direction values return intact after an override, that the latch read ignores the pin level, the two-edge pin synchronizer latency, the gating of the strobes by the direction bits, and bus ownership taking hold inside reset.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    typedef enum logic [2:0] {
        OWN_GPIO    = 3'd0,
        OWN_BUS     = 3'd1,
        OWN_PSP     = 3'd2,
        OWN_ALT     = 3'd3,
        OWN_PSP_ALT = 3'd4
    } own_state_t;

    localparam logic [1:0] MODE_MCU = 2'b00;

    localparam logic [1:0] ADDR_PORT = 2'd0;
    localparam logic [1:0] ADDR_LAT  = 2'd1;
    localparam logic [1:0] ADDR_DIR  = 2'd2;
    localparam logic [1:0] ADDR_NONE = 2'd3;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_mux_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [1:0]       addr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] latch_o,
    output logic [WIDTH-1:0] dir_o
);
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '1;
        end else if (we_i) begin
            unique case (addr_i)
                ADDR_PORT, ADDR_LAT: latch_q <= wdata_i;
                ADDR_DIR:            dir_q   <= wdata_i;
                default:             ;
            endcase
        end
    end

    assign latch_o = latch_q;
    assign dir_o   = dir_q;
endmodule

// File: rtl/gpio_own_fsm.sv
module gpio_own_fsm
    import gpio_mux_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mem_mode_i,
    input  logic       bus_dis_i,
    input  logic       psp_en_i,
    input  logic       alt_sel_n_i,
    output own_state_t state_o,
    output logic       bus_own_o,
    output logic       psp_own_o,
    output logic       alt_own_o
);
    own_state_t state_q;
    own_state_t state_d;

    // next-state decode, shared by reset and run so reset lands in the mode's owner
    always_comb begin
        if (mem_mode_i != MODE_MCU) begin
            state_d = bus_dis_i ? OWN_GPIO : OWN_BUS;
        end else begin
            unique case ({psp_en_i, alt_sel_n_i})
                2'b10:   state_d = OWN_PSP_ALT;
                2'b11:   state_d = OWN_PSP;
                2'b00:   state_d = OWN_ALT;
                default: state_d = OWN_GPIO;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_comb begin
        bus_own_o = 1'b0;
        psp_own_o = 1'b0;
        alt_own_o = 1'b0;
        unique case (state_q)
            OWN_BUS:     bus_own_o = 1'b1;
            OWN_PSP:     psp_own_o = 1'b1;
            OWN_ALT:     alt_own_o = 1'b1;
            OWN_PSP_ALT: begin
                psp_own_o = 1'b1;
                alt_own_o = 1'b1;
            end
            default:     ;
        endcase
    end

    assign state_o = state_q;

    logic unused_rst;
    assign unused_rst = rst_n;
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int WIDTH    = 8,
    parameter int PSP_PINS = 3,
    parameter int ALT_PIN  = 7
) (
    input  logic             bus_own_i,
    input  logic             psp_own_i,
    input  logic             alt_own_i,
    input  logic [WIDTH-1:0] dir_i,
    input  logic [WIDTH-1:0] latch_i,
    input  logic             bus_drive_i,
    input  logic [WIDTH-1:0] bus_out_i,
    input  logic             ccp_drive_i,
    input  logic             ccp_out_i,
    output logic [WIDTH-1:0] pad_oe_o,
    output logic [WIDTH-1:0] pad_out_o
);
    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        localparam bit IS_PSP = (p < PSP_PINS);
        localparam bit IS_ALT = (p == ALT_PIN);

        always_comb begin
            // priority: bus, strobe inputs, alternate output, GPIO
            if (bus_own_i) begin
                pad_oe_o[p]  = bus_drive_i;
                pad_out_o[p] = bus_out_i[p];
            end else if (IS_PSP && psp_own_i) begin
                pad_oe_o[p]  = 1'b0;
                pad_out_o[p] = 1'b0;
            end else if (IS_ALT && alt_own_i) begin
                pad_oe_o[p]  = ccp_drive_i;
                pad_out_o[p] = ccp_out_i;
            end else begin
                pad_oe_o[p]  = ~dir_i[p];
                pad_out_o[p] = latch_i[p];
            end
        end
    end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpio_mux_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int PSP_PINS = 3,
    parameter int ALT_PIN  = WIDTH - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [WIDTH-1:0] reg_wdata,
    output logic [WIDTH-1:0] reg_rdata,
    input  logic [1:0]       mem_mode,
    input  logic             bus_dis,
    input  logic             psp_en,
    input  logic             alt_sel_n,
    input  logic             bus_drive,
    input  logic [WIDTH-1:0] bus_out,
    output logic [WIDTH-1:0] bus_in,
    input  logic             ccp_drive,
    input  logic             ccp_out,
    output logic [PSP_PINS-1:0] psp_ctl,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out
);
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pin_sync;
    own_state_t       own_state;
    logic             bus_own;
    logic             psp_own;
    logic             alt_own;

    gpio_port_regs #(.WIDTH(WIDTH)) regs_i (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .latch_o(latch_q), .dir_o(dir_q)
    );

    gpio_pin_sync #(.WIDTH(WIDTH)) sync_i (
        .clk(clk), .rst_n(rst_n), .raw_i(pad_in), .sync_o(pin_sync)
    );

    gpio_own_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .mem_mode_i(mem_mode), .bus_dis_i(bus_dis),
        .psp_en_i(psp_en), .alt_sel_n_i(alt_sel_n), .state_o(own_state),
        .bus_own_o(bus_own), .psp_own_o(psp_own), .alt_own_o(alt_own)
    );

    gpio_pin_mux #(.WIDTH(WIDTH), .PSP_PINS(PSP_PINS), .ALT_PIN(ALT_PIN)) mux_i (
        .bus_own_i(bus_own), .psp_own_i(psp_own), .alt_own_i(alt_own),
        .dir_i(dir_q), .latch_i(latch_q),
        .bus_drive_i(bus_drive), .bus_out_i(bus_out),
        .ccp_drive_i(ccp_drive), .ccp_out_i(ccp_out),
        .pad_oe_o(pad_oe), .pad_out_o(pad_out)
    );

    always_comb begin
        unique case (reg_addr)
            ADDR_PORT: reg_rdata = pin_sync;
            ADDR_LAT:  reg_rdata = latch_q;
            ADDR_DIR:  reg_rdata = dir_q;
            default:   reg_rdata = '0;
        endcase
    end

    // strobes only pass when the low direction bits make those pins inputs
    assign psp_ctl = (psp_own && (&dir_q[PSP_PINS-1:0])) ? pin_sync[PSP_PINS-1:0] : '1;
    assign bus_in  = pin_sync;

    logic unused_state;
    assign unused_state = ^own_state;
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
    parameter int WIDTH    = 8,
    parameter int PSP_PINS = 3,
    parameter int ALT_PIN  = WIDTH - 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [1:0]       reg_addr,
    input logic [WIDTH-1:0] reg_wdata,
    input logic [1:0]       mem_mode,
    input logic             bus_dis,
    input logic             psp_en,
    input logic             alt_sel_n,
    input logic             bus_drive,
    input logic [WIDTH-1:0] bus_out,
    input logic             ccp_drive,
    input logic             ccp_out,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] latch_q,
    input logic [WIDTH-1:0] dir_q
);
    assert_bus_owns_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_mode) != 2'b00 && !$past(bus_dis))
        |-> (pad_oe == {WIDTH{bus_drive}} && pad_out == bus_out));

    assert_strobe_undriven_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_mode) == 2'b00 && $past(psp_en))
        |-> (pad_oe[PSP_PINS-1:0] == '0));

    assert_alt_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_mode) == 2'b00 && !$past(alt_sel_n))
        |-> (pad_oe[ALT_PIN] == ccp_drive && pad_out[ALT_PIN] == ccp_out));

    assert_gpio_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mem_mode) == 2'b00 && !$past(psp_en) && $past(alt_sel_n))
         || ($past(mem_mode) != 2'b00 && $past(bus_dis)))
        |-> (pad_oe == ~dir_q && pad_out == latch_q));

    assert_latch_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr == 2'd0 || reg_addr == 2'd1))
        |=> (latch_q == $past(reg_wdata)));

    assert_unused_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd3) |=> ($stable(latch_q) && $stable(dir_q)));

    assert_reset_values_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (latch_q == '0 && dir_q == '1));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(
    .WIDTH(WIDTH), .PSP_PINS(PSP_PINS), .ALT_PIN(ALT_PIN)
) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_mode(mem_mode), .bus_dis(bus_dis),
    .psp_en(psp_en), .alt_sel_n(alt_sel_n), .bus_drive(bus_drive),
    .bus_out(bus_out), .ccp_drive(ccp_drive), .ccp_out(ccp_out),
    .pad_oe(pad_oe), .pad_out(pad_out), .latch_q(latch_q), .dir_q(dir_q)
);

// File: tb/gpio_mux_port_tb_top.sv
module gpio_mux_port_tb_top;
    localparam int W = 8;
    localparam int NVEC = 8;
    // {mode[1:0], bus_dis, psp_en, alt_sel_n, dir, latch, exp_oe, exp_out}
    localparam int VW = 5 + 4 * W;
    localparam logic [VW-1:0] VEC [0:NVEC-1] = '{
        {2'b00, 1'b0, 1'b0, 1'b1, 8'hF0, 8'h5A, 8'h0F, 8'h5A},  // R2 mixed dirs
        {2'b00, 1'b0, 1'b0, 1'b1, 8'h00, 8'hA5, 8'hFF, 8'hA5},  // R2 all outputs
        {2'b10, 1'b0, 1'b0, 1'b1, 8'h00, 8'hA5, 8'hFF, 8'hC3},  // R5 extended
        {2'b01, 1'b1, 1'b1, 1'b0, 8'h3C, 8'h0F, 8'hC3, 8'h0F},  // R6 bus disabled
        {2'b00, 1'b0, 1'b1, 1'b1, 8'h07, 8'hFF, 8'hF8, 8'hF8},  // R7 strobes
        {2'b00, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 8'h80, 8'h80},  // R8 alt pin
        {2'b00, 1'b0, 1'b1, 1'b0, 8'h00, 8'h55, 8'hF8, 8'hD0},  // R7 R8 both
        {2'b11, 1'b0, 1'b1, 1'b0, 8'h00, 8'h55, 8'hFF, 8'hC3}   // R5 mode 3
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic [1:0] mem_mode = 2'b00;
    logic bus_dis = 1'b0, psp_en = 1'b0, alt_sel_n = 1'b1;
    logic bus_drive = 1'b1;
    logic [W-1:0] bus_out = 8'hC3;
    logic [W-1:0] bus_in;
    logic ccp_drive = 1'b1, ccp_out = 1'b1;
    logic [2:0] psp_ctl;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_oe, pad_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_mux_port dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_mode(mem_mode),
        .bus_dis(bus_dis), .psp_en(psp_en), .alt_sel_n(alt_sel_n),
        .bus_drive(bus_drive), .bus_out(bus_out), .bus_in(bus_in),
        .ccp_drive(ccp_drive), .ccp_out(ccp_out), .psp_ctl(psp_ctl),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_mode(input logic [1:0] m, input logic bd, input logic pe, input logic an);
        @(negedge clk);
        mem_mode = m; bus_dis = bd; psp_en = pe; alt_sel_n = an;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [W-1:0] v;
        // R1 reset state
        repeat (3) @(negedge clk);
        rd(2'd2, v); check("R1 dir", v, 8'hFF);
        rd(2'd1, v); check("R1 latch", v, 8'h00);
        check("R1 oe", pad_oe, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [VW-1:0] e;
            e = VEC[i];
            set_mode(2'b00, 1'b0, 1'b0, 1'b1);
            wr(2'd2, e[4*W-1:3*W]);
            wr(2'd1, e[3*W-1:2*W]);
            set_mode(e[VW-1:VW-2], e[VW-3], e[VW-4], e[VW-5]);
            @(negedge clk); @(negedge clk);
            check($sformatf("R2/R5-R8 vec%0d oe", i), pad_oe, e[2*W-1:W]);
            check($sformatf("R2/R5-R8 vec%0d out", i), pad_out, e[W-1:0]);
        end

        // R3 latch read ignores pins; R4 port read latency and port write
        set_mode(2'b00, 1'b0, 1'b0, 1'b1);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h3C);
        pad_in = 8'hC3;
        rd(2'd1, v); check("R3 latch read", v, 8'h3C);
        @(negedge clk);
        rd(2'd0, v); check("R4 one edge", v, 8'h00);
        @(negedge clk);
        rd(2'd0, v); check("R4 two edges", v, 8'hC3);
        check("R4 bus_in", bus_in, 8'hC3);
        wr(2'd0, 8'h99);
        rd(2'd1, v); check("R4 port write", v, 8'h99);
        check("R4 pad_out", pad_out, 8'h99);

        // R11 unused address
        wr(2'd3, 8'h12);
        rd(2'd3, v); check("R11 read", v, 8'h00);
        rd(2'd1, v); check("R11 latch", v, 8'h99);
        rd(2'd2, v); check("R11 dir", v, 8'h00);

        // R7 strobe gating by direction bits
        wr(2'd2, 8'h07);
        pad_in = 8'h05;
        set_mode(2'b00, 1'b0, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        check("R7 strobes", {5'd0, psp_ctl}, 8'h05);
        wr(2'd2, 8'h06);
        #1 check("R7 gated", {5'd0, psp_ctl}, 8'h07);

        // R9 values survive bus override; R12 one-edge latency
        set_mode(2'b00, 1'b0, 1'b0, 1'b1);
        wr(2'd2, 8'hF0);
        wr(2'd1, 8'h66);
        set_mode(2'b10, 1'b0, 1'b0, 1'b1);
        #1 check("R12 before edge", pad_oe, 8'h0F);
        @(negedge clk);
        check("R12 after edge", pad_oe, 8'hFF);
        check("R9 bus out", pad_out, 8'hC3);
        set_mode(2'b00, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R9 oe restored", pad_oe, 8'h0F);
        check("R9 out restored", pad_out, 8'h66);

        // R10 reset in extended mode
        set_mode(2'b10, 1'b0, 1'b0, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 oe in reset", pad_oe, 8'hFF);
        check("R10 out in reset", pad_out, 8'hC3);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R10 oe after reset", pad_oe, 8'hFF);
        set_mode(2'b00, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R1 inputs after reset", pad_oe, 8'h00);

        finish_run();
    end
endmodule